// File: doc/BRIEF.md
# Debug Trace Capture Buffer with Saturating Valid Count

This block is the storage end of an on-chip debug unit. After the host arms a trace run, the block writes each data word that the trigger logic flags into an eight-entry circular store. A separate four-bit counter tracks how many stored words hold valid data. When the store is full, each new word replaces the oldest one. The counter stops at eight while capture goes on.

When the run stops, the host first reads the count from a byte-wide, read-only status register. It then pulls the captured words out one at a time, starting with the oldest. Reading never lowers the count, so the host uses the count to decide how many words to fetch.

The block has two resets. Power-on always clears the count. A system reset also clears it, except when the unit is enabled and tracing is not in begin-trigger mode. In that case the reset ends the run and keeps the count, the stored words and the read position, so the host can still collect the trace afterwards.

Top module: `trace_capture_buf`

## Requirements
- R1: The status byte reads out at register offset 0x0F: the valid count sits in bits 3:0 and bits 7:4 always read 0. Any other offset reads 0x00.
- R2: Arming (arm_i high for one cycle, with no reset active) clears the valid count to 0 on the next edge and restarts capture from an empty store.
- R3: While armed, each cycle with cap_valid_i high stores one word and raises the count by exactly one, as long as the count is below eight.
- R4: The count never exceeds 8 (binary 1000). Once it reaches 8 it stays at 8 while captures continue.
- R5: With the store full, each new capture overwrites the oldest entry. Read-out then starts from the oldest surviving word.
- R6: While not armed, cap_valid_i has no effect: neither the count nor any stored word changes.
- R7: When not armed, each rd_pop_i pulse moves the read position to the next-newer word, wrapping modulo eight. Pops never change the count.
- R8: Whenever the count is 0, rd_data_o reads 0.
- R9: A system reset (sys_rst_n low) while trc_en_i is 1 and trc_begin_i is 0 ends the run. It leaves the count, the stored words and the read position unchanged.
- R10: A system reset under any other setting of trc_en_i and trc_begin_i clears the count to 0. A power-on reset (por_n low) clears it regardless of those inputs.
- R11: rd_pop_i is ignored while the unit is armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| sys_rst_n | input | 1 | System reset, active low, synchronous |
| trc_en_i | input | 1 | Debug unit enabled |
| trc_begin_i | input | 1 | Begin-trigger trace mode selected |
| arm_i | input | 1 | Start a trace run (pulse) |
| disarm_i | input | 1 | Stop the trace run (pulse) |
| cap_valid_i | input | 1 | Capture cap_data_i this cycle |
| cap_data_i | input | 16 | Word to capture |
| rd_pop_i | input | 1 | Advance to the next stored word |
| rd_data_o | output | 16 | Word at the current read position, or 0 when the count is 0 |
| reg_addr_i | input | 5 | Status register read address |
| reg_rdata_o | output | 8 | Status register read data |

## Verification
The hardest state to reach is a reset that ends a run but keeps the trace. To get there, the unit must be enabled with begin-trigger mode off, armed, and loaded with a partial trace whose words are distinct. The reset then has to arrive while the run is still armed. The bench builds this state in that order. After the reset it checks three things: the count is unchanged, further captures are ignored because the unit is no longer armed, and read-out still returns the first word captured. The saturation-and-overwrite case is reached by capturing eleven distinct words, so that read-out must begin at the fourth word and wrap back to it after eight pops.

// File: rtl/trc_pkg.sv
`timescale 1ns/1ps
package trc_pkg;
   localparam int unsigned TRC_DEPTH_DEF  = 8;
   localparam int unsigned TRC_DATA_W_DEF = 16;
   localparam int unsigned TRC_ADDR_W_DEF = 5;
   localparam int unsigned TRC_STAT_OFS   = 'h0F;

   typedef enum logic [1:0] {
      RST_NONE = 2'd0,
      RST_KEEP = 2'd1,
      RST_DROP = 2'd2
   } trc_rst_e;

   function automatic trc_rst_e trc_rst_kind(input logic por_n, input logic sys_rst_n,
                                             input logic en, input logic beg);
      if (!por_n)                 return RST_DROP;
      if (sys_rst_n)              return RST_NONE;
      if (en && !beg)             return RST_KEEP;
      return RST_DROP;
   endfunction
endpackage

// File: rtl/trc_store.sv
`timescale 1ns/1ps
module trc_store #(
   parameter int unsigned DEPTH     = 8,
   parameter int unsigned DATA_W    = 16,
   parameter bit          CLEAR_MEM = 1'b0,
   localparam int unsigned PTR_W    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              ptr_clr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [PTR_W-1:0]  rd_ptr,
   output logic [DATA_W-1:0] rd_word
);
   logic [PTR_W-1:0]  wr_ptr_q;
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (ptr_clr)    wr_ptr_q <= '0;
      else if (wr_en) wr_ptr_q <= wr_ptr_q + 1'b1;
   end

   generate
      if (CLEAR_MEM) begin : g_mem_clr
         always_ff @(posedge clk) begin
            if (!por_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (wr_en) begin
               mem[wr_ptr_q] <= wr_data;
            end
         end
      end else begin : g_mem_plain
         always_ff @(posedge clk) begin
            if (wr_en && por_n) mem[wr_ptr_q] <= wr_data;
         end
      end
   endgenerate

   assign rd_word = mem[rd_ptr];
endmodule

// File: rtl/trc_count.sv
`timescale 1ns/1ps
module trc_count #(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             cnt_clr,
   input  logic             cnt_inc,
   output logic [CNT_W-1:0] cnt_o,
   output logic             full_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (cnt_clr)                         cnt_q <= '0;
      else if (cnt_inc && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o  = cnt_q;
   assign full_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/trc_readout.sv
`timescale 1ns/1ps
module trc_readout #(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             ptr_clr,
   input  logic             drop_oldest,
   input  logic             pop,
   output logic [PTR_W-1:0] rd_ptr_o
);
   logic [PTR_W-1:0] rd_ptr_q;

   always_ff @(posedge clk) begin
      if (ptr_clr)                  rd_ptr_q <= '0;
      else if (drop_oldest || pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
   end

   assign rd_ptr_o = rd_ptr_q;
endmodule

// File: rtl/trace_capture_buf.sv
`timescale 1ns/1ps
module trace_capture_buf
   import trc_pkg::*;
#(
   parameter int unsigned DEPTH     = TRC_DEPTH_DEF,
   parameter int unsigned DATA_W    = TRC_DATA_W_DEF,
   parameter int unsigned ADDR_W    = TRC_ADDR_W_DEF,
   parameter int unsigned STAT_OFS  = TRC_STAT_OFS,
   parameter bit          CLEAR_MEM = 1'b0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst_n,
   input  logic              trc_en_i,
   input  logic              trc_begin_i,
   input  logic              arm_i,
   input  logic              disarm_i,
   input  logic              cap_valid_i,
   input  logic [DATA_W-1:0] cap_data_i,
   input  logic              rd_pop_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic [ADDR_W-1:0] reg_addr_i,
   output logic [7:0]        reg_rdata_o
);
   localparam int unsigned PTR_W = $clog2(DEPTH);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two");
      assert (CNT_W <= 8) else $error("count does not fit the status byte");
      assert (STAT_OFS < (1 << ADDR_W)) else $error("STAT_OFS outside address range");
   end

   trc_rst_e         rst_kind;
   logic             in_reset;
   logic             armed_q;
   logic             arm_go;
   logic             capture;
   logic             pop;
   logic             clr_all;
   logic [CNT_W-1:0] cnt;
   logic             full;
   logic [PTR_W-1:0] rd_ptr;
   logic [DATA_W-1:0] rd_word;

   assign rst_kind = trc_rst_kind(por_n, sys_rst_n, trc_en_i, trc_begin_i);
   assign in_reset = (rst_kind != RST_NONE);
   assign arm_go   = arm_i && !in_reset;
   assign capture  = armed_q && cap_valid_i && !in_reset && !arm_i;
   assign pop      = rd_pop_i && !armed_q && !in_reset;
   assign clr_all  = (rst_kind == RST_DROP) || arm_go;

   always_ff @(posedge clk) begin
      if (in_reset)      armed_q <= 1'b0;
      else if (arm_i)    armed_q <= 1'b1;
      else if (disarm_i) armed_q <= 1'b0;
   end

   trc_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CLEAR_MEM(CLEAR_MEM)) u_store (
      .clk     (clk),
      .por_n   (por_n),
      .ptr_clr (clr_all),
      .wr_en   (capture),
      .wr_data (cap_data_i),
      .rd_ptr  (rd_ptr),
      .rd_word (rd_word)
   );

   trc_count #(.DEPTH(DEPTH)) u_count (
      .clk     (clk),
      .cnt_clr (clr_all),
      .cnt_inc (capture),
      .cnt_o   (cnt),
      .full_o  (full)
   );

   trc_readout #(.DEPTH(DEPTH)) u_readout (
      .clk         (clk),
      .ptr_clr     (clr_all),
      .drop_oldest (capture && full),
      .pop         (pop),
      .rd_ptr_o    (rd_ptr)
   );

   assign rd_data_o = (cnt == '0) ? '0 : rd_word;

   generate
      if (CNT_W < 8) begin : g_stat_pad
         assign reg_rdata_o = (reg_addr_i == ADDR_W'(STAT_OFS))
                              ? {{(8-CNT_W){1'b0}}, cnt} : 8'h00;
      end else begin : g_stat_full
         assign reg_rdata_o = (reg_addr_i == ADDR_W'(STAT_OFS)) ? 8'(cnt) : 8'h00;
      end
   endgenerate
endmodule

// File: rtl/trace_capture_buf_chk.sv
`timescale 1ns/1ps
module trace_capture_buf_chk #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned DATA_W = 16,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              por_n,
   input logic              sys_rst_n,
   input logic              trc_en_i,
   input logic              trc_begin_i,
   input logic              arm_i,
   input logic              cap_valid_i,
   input logic              armed,
   input logic [CNT_W-1:0]  cnt,
   input logic [DATA_W-1:0] rd_data_o,
   input logic [7:0]        reg_rdata_o
);
   localparam logic [CNT_W-1:0] CMAX = CNT_W'(DEPTH);

   p_hi_zero_r1: assert property (@(posedge clk) disable iff (!por_n)
      reg_rdata_o[7:4] == 4'h0);

   p_arm_clr_r2: assert property (@(posedge clk) disable iff (!por_n)
      (arm_i && sys_rst_n) |=> cnt == '0);

   p_cnt_inc_r3: assert property (@(posedge clk) disable iff (!por_n)
      (armed && cap_valid_i && sys_rst_n && !arm_i && cnt != CMAX)
      |=> cnt == CNT_W'($past(cnt) + 1'b1));

   p_cnt_max_r4: assert property (@(posedge clk) disable iff (!por_n)
      cnt <= CMAX);

   p_sat_hold_r4: assert property (@(posedge clk) disable iff (!por_n)
      (cnt == CMAX && sys_rst_n && !arm_i) |=> cnt == CMAX);

   p_idle_hold_r6: assert property (@(posedge clk) disable iff (!por_n)
      (!armed && !arm_i && sys_rst_n) |=> $stable(cnt));

   p_empty_zero_r8: assert property (@(posedge clk) disable iff (!por_n)
      (cnt == '0) |-> rd_data_o == '0);

   p_keep_r9: assert property (@(posedge clk) disable iff (!por_n)
      (!sys_rst_n && trc_en_i && !trc_begin_i) |=> cnt == $past(cnt));

   p_sys_clr_r10: assert property (@(posedge clk) disable iff (!por_n)
      (!sys_rst_n && !(trc_en_i && !trc_begin_i)) |=> cnt == '0);
endmodule

bind trace_capture_buf trace_capture_buf_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .por_n       (por_n),
   .sys_rst_n   (sys_rst_n),
   .trc_en_i    (trc_en_i),
   .trc_begin_i (trc_begin_i),
   .arm_i       (arm_i),
   .cap_valid_i (cap_valid_i),
   .armed       (armed_q),
   .cnt         (cnt),
   .rd_data_o   (rd_data_o),
   .reg_rdata_o (reg_rdata_o)
);

// File: tb/trace_capture_buf_tb.sv
`timescale 1ns/1ps
module trace_capture_buf_tb;
   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        sys_rst_n = 1'b1;
   logic        trc_en_i = 1'b0;
   logic        trc_begin_i = 1'b0;
   logic        arm_i = 1'b0;
   logic        disarm_i = 1'b0;
   logic        cap_valid_i = 1'b0;
   logic [15:0] cap_data_i = '0;
   logic        rd_pop_i = 1'b0;
   logic [15:0] rd_data_o;
   logic [4:0]  reg_addr_i = 5'h0F;
   logic [7:0]  reg_rdata_o;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   trace_capture_buf u_dut (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
      .trc_en_i(trc_en_i), .trc_begin_i(trc_begin_i),
      .arm_i(arm_i), .disarm_i(disarm_i),
      .cap_valid_i(cap_valid_i), .cap_data_i(cap_data_i),
      .rd_pop_i(rd_pop_i), .rd_data_o(rd_data_o),
      .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic do_arm();    arm_i = 1; step(); arm_i = 0; endtask
   task automatic do_disarm(); disarm_i = 1; step(); disarm_i = 0; endtask
   task automatic do_pop();    rd_pop_i = 1; step(); rd_pop_i = 0; endtask
   task automatic do_cap(input logic [15:0] d);
      cap_valid_i = 1; cap_data_i = d; step(); cap_valid_i = 0;
   endtask
   task automatic stat(input string req, input int exp);
      reg_addr_i = 5'h0F; #1;
      chk(req, reg_rdata_o, exp);
   endtask

   task automatic t_reset();
      stat("R10 count after power-on", 0);
      chk("R8 empty read after power-on", rd_data_o, 0);
      reg_addr_i = 5'h0E; #1;
      chk("R1 other offset reads zero", reg_rdata_o, 0);
      reg_addr_i = 5'h0F;
   endtask

   task automatic t_partial();
      do_arm();
      stat("R2 count after arm", 0);
      for (int i = 0; i < 3; i++) do_cap(16'hA000 + 16'(i));
      stat("R3 three captures", 3);
      do_disarm();
      for (int i = 0; i < 3; i++) begin
         chk("R7 partial read order", rd_data_o, 'hA000 + i);
         do_pop();
      end
      stat("R7 pops leave count", 3);
   endtask

   task automatic t_saturate();
      do_arm();
      for (int i = 0; i < 11; i++) do_cap(16'hB000 + 16'(i));
      stat("R4 count saturates at 8", 8);
      do_disarm();
      for (int i = 0; i < 8; i++) begin
         chk("R5 oldest-first after overwrite", rd_data_o, 'hB003 + i);
         do_pop();
      end
      chk("R7 read wraps modulo eight", rd_data_o, 'hB003);
      do_pop();
      stat("R7 count after nine pops", 8);
   endtask

   task automatic t_idle();
      do_cap(16'hDEAD);
      do_cap(16'hBEEF);
      stat("R6 count unchanged when disarmed", 8);
      chk("R6 read word unchanged", rd_data_o, 'hB004);
      do_pop();
      chk("R6 next word unchanged", rd_data_o, 'hB005);
   endtask

   task automatic t_pop_armed();
      do_arm();
      chk("R8 empty read after arm", rd_data_o, 0);
      do_cap(16'hC000);
      do_cap(16'hC001);
      do_pop();
      do_disarm();
      chk("R11 pop while armed ignored", rd_data_o, 'hC000);
   endtask

   task automatic t_keep_reset();
      trc_en_i = 1; trc_begin_i = 0;
      do_arm();
      for (int i = 0; i < 5; i++) do_cap(16'hE000 + 16'(i));
      sys_rst_n = 0; step(); sys_rst_n = 1;
      stat("R9 count kept over reset", 5);
      do_cap(16'hFFFF);
      stat("R9 run ended by reset", 5);
      chk("R9 trace kept over reset", rd_data_o, 'hE000);
      do_pop();
      chk("R9 second word kept", rd_data_o, 'hE001);
   endtask

   task automatic t_drop_reset();
      trc_en_i = 1; trc_begin_i = 1;
      sys_rst_n = 0; step(); sys_rst_n = 1;
      stat("R10 system reset clears count", 0);
      trc_en_i = 1; trc_begin_i = 0;
      do_arm();
      do_cap(16'h1234);
      do_disarm();
      por_n = 0; step(); por_n = 1;
      stat("R10 power-on clears count", 0);
      trc_en_i = 0;
   endtask

   initial begin
      step(); step();
      por_n = 1;
      step();
      t_reset();
      t_partial();
      t_saturate();
      t_idle();
      t_pop_armed();
      t_keep_reset();
      t_drop_reset();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #2000000;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule